// File: doc/BRIEF.md
# One-Wire Bus Slot Sequencer

This block is the timing engine for a single-wire, open-drain serial bus with a pull-up. A host gives it one command at a time: a bus reset with presence detection, a single write bit, or a single read bit. The block then produces the whole time slot on its own. It pulls the line low by asserting an output enable and releases it by removing that enable. It samples the line at fixed points in the slot, and it raises a one-cycle completion strobe when the slot is over.

All slot timing is kept in whole microseconds. A prescaler divides the system clock by the parameter `CLKS_PER_US`, and the prescaler restarts at the beginning of every slot. Each phase therefore lasts an exact number of clock cycles.

A reset command first checks for a presence answer. If one is seen, the block issues a second reset. During that second reset it measures, in microseconds, how long the line stays released before the slave pulls it low, and how long the slave then holds it low. From these two values it derives a timebase figure that software can use to scale later delays. The line input passes through a two-flop synchronizer before any sampling.

Top module: `onewire_slot_master`

## Requirements
- R1: After reset, busy, done, line_oe, presence and rd_bit are all 0.
- R2: The line is never driven high. line_oe is 1 only while busy is 1, and a released line reads as 1 through the pull-up.
- R3: Command encoding on cmd_op: 2'b01 is bus reset, 2'b10 is write of cmd_wbit, 2'b11 is read, and 2'b00 is no command. A command is taken on a rising clock edge where cmd_valid is 1, busy is 0 and cmd_op is nonzero; busy is 1 from the next cycle. Commands presented while busy are ignored.
- R4: done is high for exactly one cycle. It is high in the first cycle in which busy is 0 again after a slot.
- R5: A write of 0 holds line_oe high for 60 us. It then releases the line for 1 us, so done rises 61 us of clock cycles after the accepting edge.
- R6: A write of 1 holds line_oe high for 1 us. It then releases the line for 60 us, so done rises 61 us after the accepting edge.
- R7: A read holds line_oe high for 1 us and samples the line 13 us after the falling edge. It loads rd_bit with that sample. done rises 73 us after the accepting edge, and rd_bit does not change while idle.
- R8: A reset holds line_oe high for 480 us, releases the line and samples it 60 us later. If the line is high, presence is cleared and done rises exactly 540 us after the accepting edge.
- R9: If the 60 us sample is low, presence is set. The block then waits 420 us and drives a second 480 us low pulse. After releasing, it counts whole microseconds while the line is high (t_high) and then while it is low (t_low); each count stops at MEAS_MAX_US. It then waits a further 480 us before done.
- R10: timebase always equals (t_high + t_low) / 5 + 1, using integer division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (see R3) |
| cmd_wbit | input | 1 | Bit value for a write command |
| busy | output | 1 | A slot is in progress |
| done | output | 1 | One-cycle end-of-slot strobe |
| rd_bit | output | 1 | Last bit sampled by a read slot |
| presence | output | 1 | Presence seen in the last reset |
| line_oe | output | 1 | 1 pulls the bus line low |
| line_in | input | 1 | Bus line level, asynchronous |
| t_high | output | CNT_W | Measured released interval before presence, in us |
| t_low | output | CNT_W | Measured presence low interval, in us |
| timebase | output | CNT_W | Derived timebase figure |

## Verification
The command is accepted on a clock edge, and busy follows one cycle later. From that edge, done rises after exactly the slot's total microsecond count multiplied by CLKS_PER_US edges: 61 us for writes, 73 us for a read and 540 us for a reset with no answer. The bench counts edges from the accepting edge and samples one time unit after each edge, so the count it reports is the edge on which done became 1. The length of each low pulse is counted edge by edge from line_oe. A reset that sees presence contains measured intervals that depend on the two-flop synchronizer and the phase of the prescaler. For that case the bench compares the measured counts, and the total duration, against the slave model's intervals with a tolerance of a few microseconds, and it checks timebase against the formula.

// File: rtl/onewire_slot_master.sv
module onewire_slot_master #(
  parameter int CLKS_PER_US = 100,
  parameter int MEAS_MAX_US = 480,
  parameter int CNT_W       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_wbit,
  output logic             busy,
  output logic             done,
  output logic             rd_bit,
  output logic             presence,
  output logic             line_oe,
  input  logic             line_in,
  output logic [CNT_W-1:0] t_high,
  output logic [CNT_W-1:0] t_low,
  output logic [CNT_W-1:0] timebase
);
  localparam int PRE_W = $clog2(CLKS_PER_US + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);
  localparam logic [CNT_W-1:0] MEAS_CAP = CNT_W'(MEAS_MAX_US);

  typedef enum logic [3:0] {
    S_IDLE, S_RLOW1, S_RWAIT, S_RREST1, S_RLOW2, S_MHIGH, S_MLOW, S_RREST2,
    S_W0LOW, S_W0REC, S_W1LOW, S_W1REC, S_RDLOW, S_RDWAIT, S_RDREC
  } state_t;

  state_t           state;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] tmr, dur;
  logic [1:0]       sync;
  logic             line_s, tick, phase_end;
  logic [CNT_W:0]   sum;

  assign line_s    = sync[1];
  assign tick      = (pre == PRE_LAST);
  assign phase_end = tick && (tmr == dur - 1'b1);
  assign busy      = (state != S_IDLE);
  assign line_oe   = (state == S_RLOW1) || (state == S_RLOW2) ||
                     (state == S_W0LOW) || (state == S_W1LOW) || (state == S_RDLOW);
  assign sum       = {1'b0, t_high} + {1'b0, t_low};
  assign timebase  = CNT_W'(sum / 5 + 1);

  always_comb begin
    case (state)
      S_RLOW1, S_RLOW2, S_RREST2: dur = CNT_W'(480);
      S_RWAIT:                    dur = CNT_W'(60);
      S_RREST1:                   dur = CNT_W'(420);
      S_W0LOW, S_W1REC, S_RDREC:  dur = CNT_W'(60);
      S_RDWAIT:                   dur = CNT_W'(12);
      default:                    dur = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], line_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pre      <= '0;
      tmr      <= '0;
      done     <= 1'b0;
      rd_bit   <= 1'b0;
      presence <= 1'b0;
      t_high   <= '0;
      t_low    <= '0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        pre <= '0;
        tmr <= '0;
        if (cmd_valid) begin
          case (cmd_op)
            2'b01: begin
              state    <= S_RLOW1;
              presence <= 1'b0;
              t_high   <= '0;
              t_low    <= '0;
            end
            2'b10:   state <= cmd_wbit ? S_W1LOW : S_W0LOW;
            2'b11:   state <= S_RDLOW;
            default: state <= S_IDLE;
          endcase
        end
      end else begin
        pre <= tick ? '0 : pre + 1'b1;
        if (state == S_MHIGH) begin
          if (tick) begin
            if (!line_s)              state  <= S_MLOW;
            else if (t_high == MEAS_CAP) state <= S_RREST2;
            else                      t_high <= t_high + 1'b1;
          end
        end else if (state == S_MLOW) begin
          if (tick) begin
            if (line_s)               state <= S_RREST2;
            else if (t_low == MEAS_CAP) state <= S_RREST2;
            else                      t_low <= t_low + 1'b1;
          end
        end else if (phase_end) begin
          tmr <= '0;
          case (state)
            S_RLOW1:  state <= S_RWAIT;
            S_RWAIT: begin
              presence <= !line_s;
              if (line_s) begin
                state <= S_IDLE;
                done  <= 1'b1;
              end else begin
                state <= S_RREST1;
              end
            end
            S_RREST1: state <= S_RLOW2;
            S_RLOW2:  state <= S_MHIGH;
            S_W0LOW:  state <= S_W0REC;
            S_W1LOW:  state <= S_W1REC;
            S_RDLOW:  state <= S_RDWAIT;
            S_RDWAIT: begin
              rd_bit <= line_s;
              state  <= S_RDREC;
            end
            default: begin
              state <= S_IDLE;
              done  <= 1'b1;
            end
          endcase
        end else if (tick) begin
          tmr <= tmr + 1'b1;
        end
      end
    end
  end
endmodule

module onewire_slot_master_chk #(
  parameter int MEAS_MAX_US = 480,
  parameter int CNT_W       = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic             busy,
  input logic             done,
  input logic             rd_bit,
  input logic             line_oe,
  input logic [CNT_W-1:0] t_high,
  input logic [CNT_W-1:0] t_low
);
  assert_oe_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_oe);
  assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op != 2'b00) |=> busy);
  assert_no_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cmd_valid && cmd_op != 2'b00)) |=> !busy);
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rd_bit));
  assert_meas_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (t_high <= CNT_W'(MEAS_MAX_US)) && (t_low <= CNT_W'(MEAS_MAX_US)));
endmodule

bind onewire_slot_master onewire_slot_master_chk #(
  .MEAS_MAX_US(MEAS_MAX_US), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .done(done), .rd_bit(rd_bit), .line_oe(line_oe),
  .t_high(t_high), .t_low(t_low)
);

// File: tb/tb_onewire_slot_master.sv
`timescale 1ns/1ps
module tb_onewire_slot_master;
  localparam int CPU   = 4;
  localparam int CW    = 10;
  localparam int PDH   = 20;
  localparam int PDL   = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic cmd_wbit = 1'b0;
  logic busy, done, rd_bit, presence, line_oe, line_in;
  logic [CW-1:0] t_high, t_low, timebase;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  onewire_slot_master #(.CLKS_PER_US(CPU), .MEAS_MAX_US(480), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wbit(cmd_wbit), .busy(busy), .done(done), .rd_bit(rd_bit),
    .presence(presence), .line_oe(line_oe), .line_in(line_in),
    .t_high(t_high), .t_low(t_low), .timebase(timebase)
  );

  // slave model
  logic slave_en = 1'b1;
  logic slave_rbit = 1'b1;
  logic oe_q = 1'b0;
  logic wr_seen = 1'b1;
  int lowlen = 0, pcnt = 0, rcnt = 0, wcnt = 0;
  logic slave_pull;
  assign slave_pull = (pcnt >= PDH*CPU) || (rcnt != 0);
  assign line_in = !(line_oe || slave_pull);

  always @(posedge clk) begin
    oe_q   <= line_oe;
    lowlen <= line_oe ? lowlen + 1 : 0;
    if (line_oe && !oe_q) begin
      wcnt <= 1;
      if (!slave_rbit) rcnt <= 1;
    end else begin
      if (rcnt != 0) rcnt <= (rcnt < 30*CPU) ? rcnt + 1 : 0;
      if (wcnt != 0) begin
        if (wcnt == 30*CPU) begin wr_seen <= line_in; wcnt <= 0; end
        else wcnt <= wcnt + 1;
      end
    end
    if (!line_oe && oe_q && lowlen >= 400*CPU && slave_en) pcnt <= 1;
    else if (pcnt != 0) pcnt <= (pcnt < (PDH+PDL)*CPU) ? pcnt + 1 : 0;
  end

  // low pulse monitor
  int cur_low = 0, first_low = 0, last_low = 0, npulse = 0;
  always @(posedge clk) begin
    if (line_oe) cur_low <= cur_low + 1;
    else if (cur_low != 0) begin
      if (npulse == 0) first_low <= cur_low;
      last_low <= cur_low;
      npulse   <= npulse + 1;
      cur_low  <= 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic wb, output int n);
    @(negedge clk);
    npulse = 0;
    cmd_valid = 1'b1; cmd_op = op; cmd_wbit = wb;
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_op = 2'b00;
    n = 0;
    for (int k = 0; k < 20000; k++) begin
      @(posedge clk); #1;
      n++;
      if (done) break;
    end
  endtask

  task automatic t_reset_state;
    #1;
    check(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    check(line_oe == 0, "R1 line_oe", line_oe, 0);
    check(presence == 0 && rd_bit == 0, "R1 presence/rd_bit", {presence, rd_bit}, 0);
  endtask

  task automatic t_write(input logic b);
    int n;
    issue(2'b10, b, n);
    check(n == 61*CPU, b ? "R6 slot length" : "R5 slot length", n, 61*CPU);
    check(first_low == (b ? 1 : 60)*CPU, b ? "R6 low time" : "R5 low time",
          first_low, (b ? 1 : 60)*CPU);
    repeat (CPU*31) @(posedge clk);
    check(wr_seen == b, b ? "R6 bit seen" : "R5 bit seen", wr_seen, b);
    @(posedge clk); #1;
    check(done == 0 && busy == 0, "R4 single done", done, 0);
  endtask

  task automatic t_read(input logic b);
    int n;
    slave_rbit = b;
    issue(2'b11, 1'b0, n);
    check(n == 73*CPU, "R7 slot length", n, 73*CPU);
    check(first_low == CPU, "R7 low time", first_low, CPU);
    check(rd_bit == b, "R7 rd_bit", rd_bit, b);
    slave_rbit = 1'b1;
    repeat (40*CPU) @(posedge clk); #1;
    check(rd_bit == b, "R7 rd_bit held idle", rd_bit, b);
  endtask

  task automatic t_reset_none;
    int n;
    slave_en = 1'b0;
    issue(2'b01, 1'b0, n);
    check(n == 540*CPU, "R8 no-presence length", n, 540*CPU);
    check(presence == 0, "R8 presence clear", presence, 0);
    check(first_low == 480*CPU, "R8 reset low", first_low, 480*CPU);
    slave_en = 1'b1;
    repeat (10) @(posedge clk);
  endtask

  task automatic t_reset_pres;
    int n, expn, d;
    issue(2'b01, 1'b0, n);
    check(presence == 1, "R9 presence set", presence, 1);
    check(npulse == 2, "R9 two reset pulses", npulse, 2);
    check(first_low == 480*CPU && last_low == 480*CPU, "R9 pulse lengths", last_low, 480*CPU);
    d = int'(t_high) - PDH;
    check(d >= -2 && d <= 2, "R9 t_high", t_high, PDH);
    d = int'(t_low) - PDL;
    check(d >= -2 && d <= 2, "R9 t_low", t_low, PDL);
    check(int'(timebase) == (int'(t_high) + int'(t_low)) / 5 + 1, "R10 timebase",
          timebase, (int'(t_high) + int'(t_low)) / 5 + 1);
    expn = (1920 + PDH + PDL + 2) * CPU;
    check(n >= expn - 3*CPU && n <= expn + 3*CPU, "R9 total length", n, expn);
    repeat (10) @(posedge clk);
  endtask

  task automatic t_ignore;
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    check(busy == 0 && line_oe == 0, "R3 null op ignored", busy, 0);
    // write 1 with a read pushed in mid-slot
    fork
      issue(2'b10, 1'b1, n);
      begin
        repeat (10*CPU) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b11;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
      end
    join
    check(n == 61*CPU, "R3 busy command ignored, length", n, 61*CPU);
    repeat (5) @(posedge clk); #1;
    check(busy == 0, "R3 no second slot", busy, 0);
    check(rd_bit == 0, "R3 rd_bit untouched", rd_bit, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_reset_state();
    t_write(1'b0);
    t_write(1'b1);
    t_read(1'b0);
    t_ignore();
    t_read(1'b1);
    t_reset_none();
    t_reset_pres();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule